// File: doc/BRIEF.md
# Reference Clock Loss Supervisor

This block decides where a microcontroller's system clock comes from. It watches sampled rising edges of an external reference and picks one of three sources. The first is an internal free-running backup oscillator. The second is the reference driven straight through. The third is the multiplied path, which is used once it has locked. The analog loop, the oscillator and the glitch-free clock switch sit outside the block. It only drives the select code and the status lines that those parts and the CPU use.

After power becomes good, a warm-up window runs and a usable clock is declared, even with no reference present. In that case the system runs from the backup oscillator at a few MHz. Once reference edges arrive steadily, a lock window starts. When that window completes, the multiplied path is selected. A reset-extension output holds the CPU in reset until that first lock, so software starts at the target speed. If the reference vanishes while locked, the block does three things: it pulses an interrupt, it sets a sticky flag, and it falls back to the backup clock so that emergency code can still run. All windows are counted in backup-clock ticks, and their lengths are parameters.

Top module: `clk_loss_supervisor`

## Requirements
- R1: While reset is high, the mode straps are captured. After reset the outputs read: clk_sel = 0 (backup), clk_ok = 0, lock = 0, loss_irq = 0, loss_flag = 0, rst_ext = 1.
- R2: WARM_T backup ticks after pwr_good rises, clk_ok goes to 1. This happens even when no reference edge has ever arrived, and clk_sel then stays 0 (backup). Whenever clk_sel is nonzero, clk_ok is 1.
- R3: If no reference edge arrives for MISS_WIN backup ticks, the reference is judged missing. An edge train slower than that never counts as stable.
- R4: The reference is judged stable after STABLE_N consecutive edges, each arriving before the missing window expires.
- R5: In a multiplied mode with pll_off = 0, a stable reference held for LOCK_T backup ticks makes lock = 1 and clk_sel = 2 (multiplied). lock = 1 always comes with clk_sel = 2.
- R6: If the reference stops being stable while locked, loss_irq pulses for exactly one cycle, lock clears and clk_sel returns to 0.
- R7: loss_flag sets together with the loss_irq pulse. It holds until irq_clr is 1, and a loss in the same cycle wins over the clear.
- R8: Strap codes 3'b001 and 3'b011 select direct drive. Every other code is a multiplied mode, and 3'b100 is the default factor of 4.5. In direct drive, clk_sel = 1 while the reference is stable (and clk_ok = 1), otherwise 0, and lock never sets. Strap changes after reset have no effect.
- R9: pll_off = 1 turns the multiplied path off. lock is 0 in the next cycle, without a loss interrupt, and clk_sel = 1 while the reference is stable.
- R10: rst_ext falls when the first lock is reached. In direct drive, or with pll_off = 1, it falls when clk_ok rises instead. Once low, it stays low through a later loss.
- R11: After a loss, lock returns only after the reference is stable again and a further full LOCK_T tick window has passed.
- R12: pwr_good = 0 returns the block to its power-down state in the next cycle: clk_ok = 0, lock = 0, clk_sel = 0, rst_ext = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps captured while high |
| bkp_tick | input | 1 | One-cycle enable per backup-oscillator period |
| ref_edge | input | 1 | One-cycle pulse per sampled reference rising edge |
| strap_mode | input | 3 | Mode straps, latched during reset |
| pll_off | input | 1 | Turns the multiplied path off |
| pwr_good | input | 1 | Supply is within range |
| irq_clr | input | 1 | Write-one-to-clear for loss_flag |
| clk_sel | output | 2 | 0 backup, 1 direct reference, 2 multiplied |
| clk_ok | output | 1 | A usable clock is available |
| lock | output | 1 | Multiplied path locked |
| loss_irq | output | 1 | One-cycle pulse on loss of lock |
| loss_flag | output | 1 | Sticky loss status |
| rst_ext | output | 1 | Reset-extension request |

## Verification
Every output is a register loaded from the next sequencer state and the current reference judgement. A change on pwr_good, pll_off or irq_clr therefore appears one clock later. Window expiries appear one clock after the backup tick that completes the window. A reference edge changes the stability judgement one clock after it arrives, and the select code follows one clock after that. The bench's behavioural model applies each input at the same edge the design does, and it compares all six outputs on the falling edge of every cycle. Scenario checks are placed well inside or well outside the windows, so their timing cannot be in doubt.

// File: rtl/clksup_pkg.sv
package clksup_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WARM = 3'd1,
    ST_FREE = 3'd2,
    ST_SYNC = 3'd3,
    ST_LOCK = 3'd4
  } sup_state_t;

  typedef enum logic [1:0] {
    SEL_BACKUP = 2'd0,
    SEL_DIRECT = 2'd1,
    SEL_MULT   = 2'd2
  } clk_src_t;

  function automatic logic strap_is_direct(input logic [2:0] s);
    return (s == 3'b001) || (s == 3'b011);
  endfunction
endpackage

// File: rtl/ref_watch.sv
module ref_watch #(
  parameter int MISS_WIN = 64,
  parameter int STABLE_N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic edge_in,
  output logic ref_ok
);
  localparam int GW = $clog2(MISS_WIN + 1);
  localparam int SW = $clog2(STABLE_N + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(MISS_WIN);
  localparam logic [SW-1:0] STB_MAX = SW'(STABLE_N);

  logic [GW-1:0] gap_q;
  logic [SW-1:0] stb_q;
  logic          missing;

  assign missing = (gap_q == GAP_MAX);
  assign ref_ok  = (stb_q == STB_MAX) && !missing;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_MAX;
      stb_q <= '0;
    end else if (edge_in) begin
      gap_q <= '0;
      if (missing)              stb_q <= SW'(1);
      else if (stb_q != STB_MAX) stb_q <= stb_q + SW'(1);
    end else begin
      if (tick && !missing) gap_q <= gap_q + GW'(1);
      if (missing)          stb_q <= '0;
    end
  end
endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import clksup_pkg::*;
#(
  parameter int WARM_T = 4000,
  parameter int LOCK_T = 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       pwr_good,
  input  logic       pll_used,
  input  logic       ref_ok,
  output sup_state_t st_next,
  output logic       loss_next
);
  localparam int TMAX = (WARM_T > LOCK_T) ? WARM_T : LOCK_T;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] WARM_LAST = TW'(WARM_T - 1);
  localparam logic [TW-1:0] LOCK_LAST = TW'(LOCK_T - 1);

  sup_state_t    st_q;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    st_next   = st_q;
    tmr_d     = tmr_q;
    loss_next = 1'b0;
    if (!pwr_good) begin
      st_next = ST_OFF;
      tmr_d   = '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_next = ST_WARM;
          tmr_d   = '0;
        end
        ST_WARM: if (tick) begin
          if (tmr_q == WARM_LAST) begin
            st_next = ST_FREE;
            tmr_d   = '0;
          end else tmr_d = tmr_q + TW'(1);
        end
        ST_FREE: if (pll_used && ref_ok) begin
          st_next = ST_SYNC;
          tmr_d   = '0;
        end
        ST_SYNC: begin
          if (!(pll_used && ref_ok)) st_next = ST_FREE;
          else if (tick) begin
            if (tmr_q == LOCK_LAST) st_next = ST_LOCK;
            else                    tmr_d   = tmr_q + TW'(1);
          end
        end
        ST_LOCK: begin
          if (!pll_used) st_next = ST_FREE;
          else if (!ref_ok) begin
            st_next   = ST_FREE;
            loss_next = 1'b1;
          end
        end
        default: st_next = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      tmr_q <= '0;
    end else begin
      st_q  <= st_next;
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/clk_loss_supervisor.sv
module clk_loss_supervisor
  import clksup_pkg::*;
#(
  parameter int MISS_WIN = 64,
  parameter int STABLE_N = 8,
  parameter int WARM_T   = 4000,
  parameter int LOCK_T   = 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bkp_tick,
  input  logic       ref_edge,
  input  logic [2:0] strap_mode,
  input  logic       pll_off,
  input  logic       pwr_good,
  input  logic       irq_clr,
  output logic [1:0] clk_sel,
  output logic       clk_ok,
  output logic       lock,
  output logic       loss_irq,
  output logic       loss_flag,
  output logic       rst_ext
);
  logic [2:0] strap_q;
  logic       pll_used, ref_ok, loss_next, usable, release_now;
  sup_state_t st_next;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_mode;
  end

  assign pll_used = !strap_is_direct(strap_q) && !pll_off;

  ref_watch #(.MISS_WIN(MISS_WIN), .STABLE_N(STABLE_N)) u_watch (
    .clk(clk), .rst(rst), .tick(bkp_tick), .edge_in(ref_edge), .ref_ok(ref_ok)
  );

  lock_seq #(.WARM_T(WARM_T), .LOCK_T(LOCK_T)) u_seq (
    .clk(clk), .rst(rst), .tick(bkp_tick), .pwr_good(pwr_good),
    .pll_used(pll_used), .ref_ok(ref_ok), .st_next(st_next), .loss_next(loss_next)
  );

  assign usable      = (st_next == ST_FREE) || (st_next == ST_SYNC) || (st_next == ST_LOCK);
  assign release_now = pll_used ? (st_next == ST_LOCK) : usable;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sel   <= SEL_BACKUP;
      clk_ok    <= 1'b0;
      lock      <= 1'b0;
      loss_irq  <= 1'b0;
      loss_flag <= 1'b0;
      rst_ext   <= 1'b1;
    end else begin
      if (st_next == ST_LOCK)                                      clk_sel <= SEL_MULT;
      else if ((st_next == ST_FREE || st_next == ST_SYNC) && ref_ok && !pll_used) clk_sel <= SEL_DIRECT;
      else                                                         clk_sel <= SEL_BACKUP;
      clk_ok    <= usable;
      lock      <= (st_next == ST_LOCK);
      loss_irq  <= loss_next;
      loss_flag <= loss_next | (loss_flag & ~irq_clr);
      rst_ext   <= !pwr_good ? 1'b1 : (rst_ext & ~release_now);
    end
  end
endmodule

// File: rtl/clksup_chk.sv
module clksup_chk (
  input logic       clk,
  input logic       rst,
  input logic       pll_off,
  input logic       pwr_good,
  input logic [2:0] strap_q,
  input logic [1:0] clk_sel,
  input logic       clk_ok,
  input logic       lock,
  input logic       loss_irq,
  input logic       loss_flag,
  input logic       rst_ext
);
  a_r2_sel_needs_ok: assert property (@(posedge clk) disable iff (rst)
    (clk_sel != 2'd0) |-> clk_ok);
  a_r5_lock_on_mult: assert property (@(posedge clk) disable iff (rst)
    lock |-> (clk_sel == 2'd2));
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    loss_irq |=> !loss_irq);
  a_r6_irq_leaves_lock: assert property (@(posedge clk) disable iff (rst)
    loss_irq |-> (!lock && $past(lock)));
  a_r7_flag_with_irq: assert property (@(posedge clk) disable iff (rst)
    loss_irq |-> loss_flag);
  a_r8_direct_no_lock: assert property (@(posedge clk) disable iff (rst)
    (strap_q == 3'b001 || strap_q == 3'b011) |-> !lock);
  a_r9_off_drops_lock: assert property (@(posedge clk) disable iff (rst)
    pll_off |=> !lock);
  a_r10_locked_released: assert property (@(posedge clk) disable iff (rst)
    lock |-> !rst_ext);
  a_r12_power_drop: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!clk_ok && !lock && rst_ext && clk_sel == 2'd0));
endmodule

bind clk_loss_supervisor clksup_chk u_chk (
  .clk(clk), .rst(rst), .pll_off(pll_off), .pwr_good(pwr_good), .strap_q(strap_q),
  .clk_sel(clk_sel), .clk_ok(clk_ok), .lock(lock), .loss_irq(loss_irq),
  .loss_flag(loss_flag), .rst_ext(rst_ext)
);

// File: tb/clk_loss_supervisor_test.sv
module clk_loss_supervisor_test;
  localparam int MISS = 8, STAB = 4, WARM = 20, LCK = 30;

  logic clk = 0, rst = 1, bkp_tick = 0, ref_edge = 0, pll_off = 0, pwr_good = 0, irq_clr = 0;
  logic [2:0] strap_mode = 3'b100;
  logic [1:0] clk_sel;
  logic clk_ok, lock, loss_irq, loss_flag, rst_ext;

  int total = 0, bad = 0, ref_per = 0, ref_cnt = 0, cyc = 0, irq_seen = 0;
  bit done = 0;

  // behavioural reference model state
  int m_strap, m_gap, m_stab, m_st, m_tmr, m_sel, m_lock, m_ok, m_irq, m_flag, m_rext;

  clk_loss_supervisor #(.MISS_WIN(MISS), .STABLE_N(STAB), .WARM_T(WARM), .LOCK_T(LCK)) uut (
    .clk(clk), .rst(rst), .bkp_tick(bkp_tick), .ref_edge(ref_edge), .strap_mode(strap_mode),
    .pll_off(pll_off), .pwr_good(pwr_good), .irq_clr(irq_clr), .clk_sel(clk_sel),
    .clk_ok(clk_ok), .lock(lock), .loss_irq(loss_irq), .loss_flag(loss_flag), .rst_ext(rst_ext)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // stimulus generators: backup tick every second clock, reference every ref_per clocks
  always @(negedge clk) begin
    cyc <= cyc + 1;
    bkp_tick <= ~bkp_tick;
    if (ref_per == 0) begin
      ref_edge <= 1'b0;
      ref_cnt  <= 0;
    end else if (ref_cnt >= ref_per - 1) begin
      ref_edge <= 1'b1;
      ref_cnt  <= 0;
    end else begin
      ref_edge <= 1'b0;
      ref_cnt  <= ref_cnt + 1;
    end
  end

  // model: states 0 off, 1 warm, 2 free, 3 sync, 4 locked
  always @(posedge clk) begin
    if (rst) begin
      m_strap = strap_mode; m_gap = MISS; m_stab = 0; m_st = 0; m_tmr = 0;
      m_sel = 0; m_lock = 0; m_ok = 0; m_irq = 0; m_flag = 0; m_rext = 1;
    end else begin
      int nst, ntmr, loss, pll, rok;
      pll = (m_strap != 1 && m_strap != 3 && !pll_off) ? 1 : 0;
      rok = (m_stab == STAB && m_gap != MISS) ? 1 : 0;
      nst = m_st; ntmr = m_tmr; loss = 0;
      if (!pwr_good) begin nst = 0; ntmr = 0; end
      else if (m_st == 0) begin nst = 1; ntmr = 0; end
      else if (m_st == 1) begin
        if (bkp_tick) begin
          if (m_tmr == WARM - 1) begin nst = 2; ntmr = 0; end else ntmr = m_tmr + 1;
        end
      end else if (m_st == 2) begin
        if (pll && rok) begin nst = 3; ntmr = 0; end
      end else if (m_st == 3) begin
        if (!(pll && rok)) nst = 2;
        else if (bkp_tick) begin
          if (m_tmr == LCK - 1) nst = 4; else ntmr = m_tmr + 1;
        end
      end else begin
        if (!pll) nst = 2;
        else if (!rok) begin nst = 2; loss = 1; end
      end
      m_sel  = (nst == 4) ? 2 : (((nst == 2 || nst == 3) && rok && !pll) ? 1 : 0);
      m_lock = (nst == 4);
      m_ok   = (nst >= 2);
      m_irq  = loss;
      m_flag = (loss || (m_flag && !irq_clr)) ? 1 : 0;
      if (!pwr_good) m_rext = 1;
      else if (pll ? (nst == 4) : (nst >= 2)) m_rext = 0;
      if (ref_edge) begin
        m_stab = (m_gap == MISS) ? 1 : ((m_stab < STAB) ? m_stab + 1 : STAB);
        m_gap  = 0;
      end else begin
        if (m_gap == MISS) m_stab = 0;
        if (bkp_tick && m_gap < MISS) m_gap = m_gap + 1;
      end
      m_st = nst; m_tmr = ntmr;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 clk_sel", clk_sel, m_sel);
      chk("R5 lock", lock, m_lock);
      chk("R2 clk_ok", clk_ok, m_ok);
      chk("R6 loss_irq", loss_irq, m_irq);
      chk("R7 loss_flag", loss_flag, m_flag);
      chk("R10 rst_ext", rst_ext, m_rext);
      if (loss_irq) irq_seen++;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel", clk_sel, 0); chk("R1 ok", clk_ok, 0); chk("R1 lock", lock, 0);
    chk("R1 irq", loss_irq, 0); chk("R1 flag", loss_flag, 0); chk("R1 rst_ext", rst_ext, 1);
    // R2 warm-up without any reference
    pwr_good = 1;
    wait_cyc(2 * WARM - 10);
    chk("R2 not yet ok", clk_ok, 0);
    wait_cyc(20);
    chk("R2 ok without ref", clk_ok, 1); chk("R2 backup sel", clk_sel, 0);
    chk("R10 held before lock", rst_ext, 1);
    // R4/R5 steady reference (3 ticks apart) leads to lock
    ref_per = 6;
    wait_cyc(6 * STAB + 2 * LCK + 20);
    chk("R5 locked", lock, 1); chk("R5 mult sel", clk_sel, 2); chk("R10 released", rst_ext, 0);
    // R3/R6 reference stops
    irq_seen = 0;
    ref_per = 0;
    wait_cyc(2 * MISS + 30);
    chk("R6 one pulse", irq_seen, 1); chk("R6 lock dropped", lock, 0);
    chk("R6 backup sel", clk_sel, 0); chk("R7 flag set", loss_flag, 1);
    chk("R10 stays released", rst_ext, 0);
    // R7 write-one-to-clear
    irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
    chk("R7 flag cleared", loss_flag, 0);
    // R11 relock needs a full window again
    ref_per = 6;
    wait_cyc(6 * STAB + 20);
    chk("R11 not early", lock, 0);
    wait_cyc(2 * LCK + 20);
    chk("R11 relocked", lock, 1);
    // R9 multiplied path off: lock drops without interrupt, direct select
    irq_seen = 0;
    pll_off = 1;
    wait_cyc(4);
    chk("R9 lock off", lock, 0); chk("R9 direct", clk_sel, 1); chk("R9 no irq", irq_seen, 0);
    pll_off = 0;
    wait_cyc(2 * LCK + 20);
    chk("R9 relock after enable", lock, 1);
    // R12 power drop
    pwr_good = 0;
    wait_cyc(2);
    chk("R12 ok off", clk_ok, 0); chk("R12 lock off", lock, 0); chk("R12 rst_ext", rst_ext, 1);
    // R8 direct-drive strap, changed after reset
    rst = 1; strap_mode = 3'b011; ref_per = 6;
    wait_cyc(3);
    rst = 0; strap_mode = 3'b100; pwr_good = 1;
    wait_cyc(2 * WARM + 2 * LCK + 60);
    chk("R8 direct sel", clk_sel, 1); chk("R8 never lock", lock, 0); chk("R10 direct release", rst_ext, 0);
    // R3 slow reference (10 ticks apart) never stable
    ref_per = 20;
    wait_cyc(200);
    chk("R3 slow ref not stable", clk_sel, 0);
    done = 1;
  end

  initial begin
    int w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", w);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule